// File: doc/BRIEF.md
# Dual Synthesizer Configuration Loader

This block keeps the dynamic settings of two cascaded clock synthesizers and presents them as packed configuration buses. A synchronous host port with an 8-bit data path, a 2-bit byte address and a write enable fills a 21-bit control word. Bytes 0 and 1 land in shadow registers. A write to byte 2 commits the whole word at once, so the synthesizers never see a word that is only partly written. The commit also raises a one-cycle apply strobe, and the new settings take effect while the clocks keep running.

Pulled-up strap inputs give the defaults. After reset the active word follows the straps. The first commit over the host port sets a sticky override flag, and from then on the straps are ignored. The word holds five fields: input-range select, oscillator range, multiplier, output divider and signed delay. The secondary synthesizer takes every field. The primary synthesizer shares only the two range fields and has all other fields tied to zero. The block also brings out the decoded integer multiplier and divider and the delay as a signed step count. A delay code of negative zero is flagged and treated as zero.

Top module: `pll_cfg_loader`

## Requirements
- R1: While `rst` is high at a clock edge, the active word and both shadow bytes load from `strap_word`, `bus_override` clears and `cfg_apply` is low.
- R2: While `bus_override` is low, the active word copies `strap_word` on every clock edge. Once `bus_override` is high it stays high until reset, and `strap_word` has no further effect.
- R3: A write to address 0 or address 1 only updates shadow byte 0 (word bits 7:0) or shadow byte 1 (word bits 15:8). The active word and every output derived from it stay unchanged.
- R4: A write to address 2 loads the active word with {wdata[4:0], shadow byte 1, shadow byte 0} and sets `bus_override`. `cfg_apply` is high for exactly the one cycle after each such write.
- R5: A write to address 3 changes nothing. Bits 7:5 of a write to address 2 are ignored.
- R6: `host_rdata` is combinational from `host_addr`. Addresses 0 and 1 return active bits 7:0 and 15:8. Address 2 returns {3'b000, active bits 20:16}. Address 3 returns 0.
- R7: Field positions in the control word: bit 0 is the low-input-range select, bits 3:1 the oscillator range, bits 9:4 the multiplier code, bits 15:10 the divider code and bits 20:16 the delay code. `pri_cfg` and `sec_cfg` use the same layout.
- R8: `pri_cfg` carries active bits 3:0 and has bits 20:4 at zero.
- R9: `sec_cfg` equals the active word, except that a delay code of 5'b10000 is driven as 5'b00000.
- R10: `delay_negzero` is high exactly when the active delay code is 5'b10000.
- R11: `sec_mult` and `sec_div` give the integer value of the multiplier and divider codes, which is the code plus one (000000 gives 1, 111111 gives 64, 000101 gives 6).
- R12: `sec_delay_steps` is the delay code converted from sign-magnitude to two's complement, in 250 ps steps (bit 4 is the sign, 1 means negative). For example, 10011 gives -3 and 11010 gives -10. The range is -15 to +15.
- R13: When a commit and a change of `strap_word` fall on the same edge while `bus_override` is low, the committed value is what the active word takes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_we | input | 1 | Host write enable |
| host_addr | input | 2 | Host byte address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Active byte at `host_addr` |
| strap_word | input | 21 | Default control word from strap pins |
| pri_cfg | output | 21 | Primary synthesizer configuration |
| sec_cfg | output | 21 | Secondary synthesizer configuration |
| cfg_apply | output | 1 | One-cycle pulse after a commit |
| bus_override | output | 1 | Straps overridden by a host commit |
| delay_negzero | output | 1 | Active delay code is negative zero |
| sec_mult | output | 7 | Decoded multiplier, 1 to 64 |
| sec_div | output | 7 | Decoded divider, 1 to 64 |
| sec_delay_steps | output | 5 | Signed delay in 250 ps steps |

## Verification
Two functions can meet on one edge: the strap tracking that runs while no override is set, and a host commit to byte 2. The bench provokes this by changing `strap_word` in the very cycle of the first commit. The reference model requires that the committed word, not the new strap value, appears on both configuration buses and in readback. A second case changes the straps again right after the override is set, and here the outputs must hold. Back-to-back commits check that `cfg_apply` stays high for two cycles and that each word is loaded in its own cycle.

// File: rtl/pll_cfg_pkg.sv
package pll_cfg_pkg;
  localparam int WORD_W   = 21;
  localparam int BYTE_W   = 8;
  localparam int ADDR_W   = 2;
  localparam int CODE_W   = 6;
  localparam int DLY_W    = 5;
  localparam int VAL_W    = CODE_W + 1;
  localparam int LOWF_LSB = 0;
  localparam int OSC_LSB  = 1;
  localparam int OSC_W    = 3;
  localparam int MUL_LSB  = 4;
  localparam int DIV_LSB  = MUL_LSB + CODE_W;
  localparam int DLY_LSB  = DIV_LSB + CODE_W;
  localparam int SHARED_W = OSC_LSB + OSC_W;
  localparam int NBYTES   = (WORD_W + BYTE_W - 1) / BYTE_W;
  localparam int TOP_W    = WORD_W - (NBYTES - 1) * BYTE_W;
  localparam logic [DLY_W-1:0] NEG_ZERO = {1'b1, {(DLY_W-1){1'b0}}};

  typedef logic [WORD_W-1:0] word_t;

  function automatic logic [VAL_W-1:0] code_to_value(input logic [CODE_W-1:0] code);
    return {1'b0, code} + VAL_W'(1);
  endfunction

  function automatic logic signed [DLY_W-1:0] sm_to_steps(input logic [DLY_W-1:0] code);
    logic [DLY_W-1:0] mag;
    mag = {1'b0, code[DLY_W-2:0]};
    return code[DLY_W-1] ? $signed(-mag) : $signed(mag);
  endfunction

  function automatic logic [DLY_W-1:0] clean_delay(input logic [DLY_W-1:0] code);
    return (code == NEG_ZERO) ? '0 : code;
  endfunction

  function automatic word_t pack_primary(input logic [SHARED_W-1:0] shared);
    word_t w;
    w = '0;
    w[SHARED_W-1:0] = shared;
    return w;
  endfunction

  function automatic word_t pack_secondary(input word_t act);
    word_t w;
    w = act;
    w[DLY_LSB +: DLY_W] = clean_delay(act[DLY_LSB +: DLY_W]);
    return w;
  endfunction
endpackage

// File: rtl/cfg_host_regs.sv
module cfg_host_regs
  import pll_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  input  word_t             strap,
  output word_t             active,
  output logic              override,
  output logic              apply,
  output logic [BYTE_W-1:0] rdata
);
  localparam int PAD_W = NBYTES * BYTE_W;
  localparam int LAST  = NBYTES - 1;

  logic [BYTE_W-1:0] shadow [LAST];
  logic [LAST-1:0]   shadow_wr;
  logic              commit;
  logic [BYTE_W-TOP_W-1:0] unused_wdata_hi;
  logic [PAD_W-1:0]  padded;

  assign commit          = we && (addr == ADDR_W'(LAST));
  assign unused_wdata_hi = wdata[BYTE_W-1:TOP_W];

  for (genvar b = 0; b < LAST; b++) begin : g_shadow
    assign shadow_wr[b] = we && (addr == ADDR_W'(b));
    always_ff @(posedge clk) begin
      if (rst)               shadow[b] <= strap[b*BYTE_W +: BYTE_W];
      else if (shadow_wr[b]) shadow[b] <= wdata;
    end
  end

  word_t commit_word;
  always_comb begin
    commit_word = '0;
    for (int b = 0; b < LAST; b++) commit_word[b*BYTE_W +: BYTE_W] = shadow[b];
    commit_word[LAST*BYTE_W +: TOP_W] = wdata[TOP_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= strap;
      override <= 1'b0;
      apply    <= 1'b0;
    end else begin
      apply <= commit;
      if (commit) begin
        active   <= commit_word;
        override <= 1'b1;
      end else if (!override) begin
        active <= strap;
      end
    end
  end

  assign padded = PAD_W'(active);
  assign rdata  = (int'(addr) < NBYTES) ? padded[addr*BYTE_W +: BYTE_W] : '0;

  assert_apply_follows_commit_R4: assert property (@(posedge clk) disable iff (rst)
    apply |-> $past(commit));
  assert_override_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    override |=> override);
  assert_active_holds_R3: assert property (@(posedge clk) disable iff (rst)
    (override && !commit) |=> $stable(active));
endmodule

// File: rtl/cfg_field_packer.sv
module cfg_field_packer
  import pll_cfg_pkg::*;
#(
  parameter bit PRIMARY = 1'b0
) (
  input  word_t act,
  output word_t cfg
);
  if (PRIMARY) begin : g_pri
    logic unused_upper;
    assign unused_upper = ^act[WORD_W-1:SHARED_W];
    assign cfg = pack_primary(act[SHARED_W-1:0]);
  end else begin : g_sec
    assign cfg = pack_secondary(act);
  end
endmodule

// File: rtl/cfg_value_decode.sv
module cfg_value_decode
  import pll_cfg_pkg::*;
(
  input  word_t                   act,
  output logic [VAL_W-1:0]        mult,
  output logic [VAL_W-1:0]        div,
  output logic signed [DLY_W-1:0] steps,
  output logic                    negzero
);
  logic unused_low;
  assign unused_low = ^act[SHARED_W-1:0];
  assign mult    = code_to_value(act[MUL_LSB +: CODE_W]);
  assign div     = code_to_value(act[DIV_LSB +: CODE_W]);
  assign steps   = sm_to_steps(act[DLY_LSB +: DLY_W]);
  assign negzero = (act[DLY_LSB +: DLY_W] == NEG_ZERO);
endmodule

// File: rtl/pll_cfg_loader.sv
module pll_cfg_loader
  import pll_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              host_we,
  input  logic [1:0]        host_addr,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  input  logic [20:0]       strap_word,
  output logic [20:0]       pri_cfg,
  output logic [20:0]       sec_cfg,
  output logic              cfg_apply,
  output logic              bus_override,
  output logic              delay_negzero,
  output logic [6:0]        sec_mult,
  output logic [6:0]        sec_div,
  output logic signed [4:0] sec_delay_steps
);
  word_t active;
  word_t pll_cfg [2];

  cfg_host_regs u_regs (
    .clk(clk), .rst(rst), .we(host_we), .addr(host_addr), .wdata(host_wdata),
    .strap(strap_word), .active(active), .override(bus_override),
    .apply(cfg_apply), .rdata(host_rdata)
  );

  for (genvar p = 0; p < 2; p++) begin : g_pack
    cfg_field_packer #(.PRIMARY(p == 0)) u_pack (
      .act(active), .cfg(pll_cfg[p])
    );
  end

  assign pri_cfg = pll_cfg[0];
  assign sec_cfg = pll_cfg[1];

  cfg_value_decode u_dec (
    .act(active), .mult(sec_mult), .div(sec_div),
    .steps(sec_delay_steps), .negzero(delay_negzero)
  );

  assert_shared_ranges_R8: assert property (@(posedge clk) disable iff (rst)
    pri_cfg[SHARED_W-1:0] == sec_cfg[SHARED_W-1:0]);
  assert_negzero_cleared_R10: assert property (@(posedge clk) disable iff (rst)
    delay_negzero |-> (sec_cfg[DLY_LSB +: DLY_W] == '0 && sec_delay_steps == 0));
  assert_top_byte_pad_R6: assert property (@(posedge clk) disable iff (rst)
    (host_addr == 2'd2) |-> (host_rdata[7:5] == 3'b000));
  assert_apply_needs_override_R4: assert property (@(posedge clk) disable iff (rst)
    cfg_apply |-> bus_override);
endmodule

// File: tb/pll_cfg_loader_bench.sv
module pll_cfg_loader_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [20:0] strap = 21'h1_2345;
  logic [7:0] rdata;
  logic [20:0] pri_cfg, sec_cfg;
  logic apply, ovr, negz;
  logic [6:0] mult, div;
  logic signed [4:0] steps;

  int vectors = 0;
  int fails = 0;
  int cyc = 0;
  string phase = "R1";

  logic [20:0] m_act;
  logic [7:0]  m_sh0, m_sh1;
  logic        m_ovr, m_apply;

  pll_cfg_loader u_pll_cfg_loader (
    .clk(clk), .rst(rst), .host_we(we), .host_addr(addr), .host_wdata(wdata),
    .host_rdata(rdata), .strap_word(strap), .pri_cfg(pri_cfg), .sec_cfg(sec_cfg),
    .cfg_apply(apply), .bus_override(ovr), .delay_negzero(negz),
    .sec_mult(mult), .sec_div(div), .sec_delay_steps(steps)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      fails++;
      $display("FAIL watchdog (%s): actual cycle %0d expected below %0d", phase, cyc, WATCHDOG);
      report();
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    if (act != exp) begin
      fails++;
      $display("FAIL %s (phase %s): actual %0h expected %0h", req, phase, act, exp);
    end
  endtask

  task automatic model_edge;
    if (rst) begin
      m_act = strap; m_sh0 = strap[7:0]; m_sh1 = strap[15:8];
      m_ovr = 0; m_apply = 0;
    end else begin
      m_apply = we && addr == 2'd2;
      if (m_apply) begin
        m_act = {wdata[4:0], m_sh1, m_sh0};
        m_ovr = 1;
      end else if (!m_ovr) m_act = strap;
      if (we && addr == 2'd0) m_sh0 = wdata;
      if (we && addr == 2'd1) m_sh1 = wdata;
    end
  endtask

  task automatic compare;
    int d, mag, exp_steps, exp_sec, exp_rd;
    d = int'(m_act[20:16]);
    mag = d % 16;
    exp_steps = (d >= 16) ? -mag : mag;
    exp_sec = (d == 16) ? int'(m_act) % 65536 : int'(m_act);
    case (addr)
      2'd0: exp_rd = int'(m_act) % 256;
      2'd1: exp_rd = (int'(m_act) / 256) % 256;
      2'd2: exp_rd = d;
      default: exp_rd = 0;
    endcase
    vectors++;
    chk("R8 pri_cfg", int'(pri_cfg), int'(m_act) % 16);
    chk("R9 sec_cfg", int'(sec_cfg), exp_sec);
    chk("R4 cfg_apply", int'(apply), int'(m_apply));
    chk("R2 bus_override", int'(ovr), int'(m_ovr));
    chk("R10 delay_negzero", int'(negz), int'(d == 16));
    chk("R11 sec_mult", int'(mult), (int'(m_act) / 16) % 64 + 1);
    chk("R11 sec_div", int'(div), (int'(m_act) / 1024) % 64 + 1);
    chk("R12 sec_delay_steps", int'(steps), exp_steps);
    chk("R6 host_rdata", int'(rdata), exp_rd);
  endtask

  task automatic step(input logic r, input logic w, input logic [1:0] a,
                      input logic [7:0] dat, input logic [20:0] s);
    rst = r; we = w; addr = a; wdata = dat; strap = s;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  initial begin
    @(negedge clk);
    phase = "R1";
    step(1, 0, 2'd0, 8'h00, 21'h1_2345);
    step(1, 0, 2'd1, 8'h00, 21'h1_2345);
    phase = "R2";
    step(0, 0, 2'd2, 8'h00, 21'h0_BEEF);
    step(0, 0, 2'd0, 8'h00, 21'h1_0123);
    phase = "R3";
    step(0, 1, 2'd0, 8'hAB, 21'h1_0123);
    step(0, 1, 2'd1, 8'hCD, 21'h1_0123);
    phase = "R5";
    step(0, 1, 2'd3, 8'hFF, 21'h1_0123);
    step(0, 0, 2'd3, 8'h00, 21'h1_0123);
    phase = "R13";
    step(0, 1, 2'd2, 8'hF3, 21'h0_7777);
    phase = "R2";
    step(0, 0, 2'd2, 8'h00, 21'h1_5555);
    step(0, 0, 2'd0, 8'h00, 21'h0_0000);
    phase = "R7";
    step(0, 1, 2'd0, 8'h56, 21'h0_0000);
    step(0, 1, 2'd1, 8'h04, 21'h0_0000);
    step(0, 1, 2'd2, 8'h1A, 21'h0_0000);
    step(0, 0, 2'd1, 8'h00, 21'h0_0000);
    phase = "R10";
    step(0, 1, 2'd2, 8'h10, 21'h0_0000);
    step(0, 0, 2'd2, 8'h00, 21'h0_0000);
    phase = "R11";
    step(0, 1, 2'd0, 8'hF0, 21'h0_0000);
    step(0, 1, 2'd1, 8'hFF, 21'h0_0000);
    step(0, 1, 2'd2, 8'h0F, 21'h0_0000);
    step(0, 1, 2'd2, 8'h00, 21'h0_0000);
    step(0, 1, 2'd0, 8'h0F, 21'h0_0000);
    step(0, 1, 2'd1, 8'h00, 21'h0_0000);
    step(0, 1, 2'd2, 8'h1F, 21'h0_0000);
    step(0, 0, 2'd0, 8'h00, 21'h0_0000);
    phase = "R12";
    step(0, 1, 2'd2, 8'h13, 21'h0_0000);
    step(0, 1, 2'd2, 8'h05, 21'h0_0000);
    step(0, 0, 2'd3, 8'h00, 21'h0_0000);
    phase = "R1";
    step(1, 0, 2'd0, 8'h00, 21'h1_F00F);
    step(0, 0, 2'd1, 8'h00, 21'h0_A5A5);
    phase = "R4";
    step(0, 1, 2'd2, 8'h00, 21'h0_A5A5);
    step(0, 0, 2'd0, 8'h00, 21'h0_A5A5);
    for (int i = 0; i < 16; i++) begin
      phase = "R6";
      step(0, i[0], 2'(i), 8'(i * 37), 21'(i * 4099));
    end
    report();
  end
endmodule